// File: doc/BRIEF.md
# Accumulator CPU sequencer

This block is the control unit and datapath of a small one-address accumulator machine. It keeps a program counter, a memory address register, a memory data register, an instruction register and a single accumulator. It runs programs out of an external synchronous word memory. Each instruction word carries an operation code in its upper byte and an operand address in its lower byte.

Every instruction starts with a hidden fetch sequence that reads the word at the program counter and then bumps the counter. The sequencer then runs the execute steps for the decoded operation: LOAD, ADD, STORE or STOP. After LOAD, ADD and STORE the machine does not go straight back to fetch. It passes through an interrupt-check step, which looks at a sticky signed-overflow flag set by the adder. When that flag is set, the machine stops with an abnormal-end indication. A normal stop and an undefined operation code also halt the machine, and the status outputs tell these cases apart.

The memory is expected to return read data one clock after the address is presented, and to write on a clock edge when the write strobe is high. All register transfers take one clock each.

Top module: `acc_cpu_seq`

## Requirements
- R1: A synchronous active-high reset loads the program counter with parameter RESET_PC and clears the halted, abnormal-end and overflow outputs and the write strobe. Execution starts with a fetch from RESET_PC.
- R2: Fetch takes five clocks (cycle offsets 0 to 4 of an instruction). It reads the word at the program counter, takes bits [15:8] as the operation code and bits [7:0] as the operand address, and adds one to the program counter.
- R3: Operation code 0x01 (LOAD) copies memory[address] into the accumulator. Including fetch and the check step, the instruction takes 10 clocks.
- R4: Operation code 0x02 (ADD) replaces the accumulator with accumulator plus memory[address], modulo 2^16, and takes 10 clocks. A two's-complement overflow sets the overflow output from the check-step cycle (offset 9) onwards, and it stays set until reset.
- R5: Operation code 0x03 (STORE) takes 9 clocks. At offset 7 it drives mem_we high for exactly one clock, with mem_addr equal to the operand address and mem_wdata equal to the accumulator.
- R6: LOAD, ADD and STORE each end with one check cycle. If overflow is clear there, the next fetch starts in the following cycle. If overflow is set, halted and abend both rise in the following cycle.
- R7: Operation code 0x04 (STOP) raises halted with abend low at offset 5.
- R8: Every other operation code, 0x00 and 0x05 to 0xFF included, raises both halted and abend at offset 5.
- R9: Once halted, the machine issues no further memory writes and its status outputs hold until reset.
- R10: The program LOAD x20, ADD x21, STORE x22, STOP placed from x23, with 450 at x20 and 300 at x21, leaves 750 at x22 and ends normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | ADDR_W | Memory address, taken from the address register |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | OP_W+ADDR_W | Memory write data, taken from the data register |
| mem_rdata | input | OP_W+ADDR_W | Memory read data, valid one clock after the address |
| halted | output | 1 | Machine has stopped |
| abend | output | 1 | Stop was abnormal (overflow or undefined operation) |
| ovf | output | 1 | Sticky signed-overflow flag of the adder |

## Verification
The two functions that meet are the adder's overflow detection, which lands on the edge that ends the accumulator write, and the check step's halt decision, which reads that flag in the very next cycle. A slip of one cycle between them either lets one more instruction run or halts a program that should continue. Several programs provoke the crossing: one with positive overflow, one with negative overflow, each followed by a STORE that must never be issued, and one with a wrap to zero that must not count as overflow. A behavioural instruction-level model in the bench expands each instruction into its expected per-cycle outputs, and every clock is compared against it.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

  // micro-states of the sequencer
  typedef enum logic [3:0] {
    ST_F_MAR,   // address register <- program counter
    ST_F_WAIT,  // memory read latency
    ST_F_MDR,   // data register <- memory
    ST_F_IR,    // instruction register <- data register, pc + 1
    ST_DEC,     // dispatch on operation code
    ST_X_MAR,   // address register <- operand address
    ST_X_WAIT,  // memory read latency
    ST_X_MDR,   // data register <- memory
    ST_X_ALU,   // accumulator update
    ST_S_MDR,   // data register <- accumulator
    ST_S_WR,    // memory write
    ST_CHK,     // interrupt check (overflow only)
    ST_HALT
  } seq_state_e;

  // per-cycle datapath strobes
  typedef struct packed {
    logic mar_pc;
    logic mar_opnd;
    logic mdr_mem;
    logic mdr_acc;
    logic ir_ld;
    logic pc_inc;
    logic acc_ld;
    logic acc_add;
    logic we;
  } seq_ctl_t;

  localparam int OPC_LOAD  = 1;
  localparam int OPC_ADD   = 2;
  localparam int OPC_STORE = 3;
  localparam int OPC_STOP  = 4;

endpackage

// File: rtl/acc_seq_datapath.sv
module acc_seq_datapath
  import acc_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int OP_W   = 8,
  parameter logic [ADDR_W-1:0] RESET_PC = '0,
  localparam int DW = OP_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_ctl_t          ctl,
  input  logic [DW-1:0]     mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic [OP_W-1:0]   ir_op,
  output logic              ov
);

  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DW-1:0]     mdr_q, ir_q, acc_q, sum;
  logic              ov_q, ov_det;

  assign sum    = acc_q + mdr_q;
  assign ov_det = (acc_q[DW-1] == mdr_q[DW-1]) && (sum[DW-1] != acc_q[DW-1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= RESET_PC;
      mar_q <= '0;
      mdr_q <= '0;
      ir_q  <= '0;
      acc_q <= '0;
      ov_q  <= 1'b0;
    end else begin
      if (ctl.mar_pc)   mar_q <= pc_q;
      if (ctl.mar_opnd) mar_q <= ir_q[ADDR_W-1:0];
      if (ctl.mdr_mem)  mdr_q <= mem_rdata;
      if (ctl.mdr_acc)  mdr_q <= acc_q;
      if (ctl.ir_ld)    ir_q  <= mdr_q;
      if (ctl.pc_inc)   pc_q  <= pc_q + 1'b1;
      if (ctl.acc_ld)   acc_q <= mdr_q;
      if (ctl.acc_add) begin
        acc_q <= sum;
        if (ov_det) ov_q <= 1'b1;
      end
    end
  end

  assign mem_addr  = mar_q;
  assign mem_wdata = mdr_q;
  assign ir_op     = ir_q[DW-1 -: OP_W];
  assign ov        = ov_q;

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    ctl.pc_inc |=> pc_q == $past(pc_q) + 1'b1);
  assert_load_copy_R3: assert property (@(posedge clk) disable iff (rst)
    ctl.acc_ld |=> acc_q == $past(mdr_q));
  assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    ov_q |=> ov_q);

endmodule

// File: rtl/acc_seq_ctrl.sv
module acc_seq_ctrl
  import acc_seq_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] ir_op,
  input  logic            ov,
  output seq_ctl_t        ctl,
  output logic            halted,
  output logic            abend
);

  seq_state_e state_q, nxt;
  logic       halted_q, abend_q;
  logic       is_load, is_add, is_store, is_stop, is_mem;

  assign is_load  = ir_op == OP_W'(OPC_LOAD);
  assign is_add   = ir_op == OP_W'(OPC_ADD);
  assign is_store = ir_op == OP_W'(OPC_STORE);
  assign is_stop  = ir_op == OP_W'(OPC_STOP);
  assign is_mem   = is_load || is_add || is_store;

  always_comb begin
    ctl = '0;
    nxt = state_q;
    unique case (state_q)
      ST_F_MAR:  begin ctl.mar_pc = 1'b1; nxt = ST_F_WAIT; end
      ST_F_WAIT: nxt = ST_F_MDR;
      ST_F_MDR:  begin ctl.mdr_mem = 1'b1; nxt = ST_F_IR; end
      ST_F_IR:   begin ctl.ir_ld = 1'b1; ctl.pc_inc = 1'b1; nxt = ST_DEC; end
      ST_DEC:    nxt = is_mem ? ST_X_MAR : ST_HALT;
      ST_X_MAR:  begin ctl.mar_opnd = 1'b1; nxt = is_store ? ST_S_MDR : ST_X_WAIT; end
      ST_X_WAIT: nxt = ST_X_MDR;
      ST_X_MDR:  begin ctl.mdr_mem = 1'b1; nxt = ST_X_ALU; end
      ST_X_ALU:  begin ctl.acc_ld = is_load; ctl.acc_add = is_add; nxt = ST_CHK; end
      ST_S_MDR:  begin ctl.mdr_acc = 1'b1; nxt = ST_S_WR; end
      ST_S_WR:   begin ctl.we = 1'b1; nxt = ST_CHK; end
      ST_CHK:    nxt = ov ? ST_HALT : ST_F_MAR;
      ST_HALT:   nxt = ST_HALT;
      default:   nxt = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_F_MAR;
      halted_q <= 1'b0;
      abend_q  <= 1'b0;
    end else begin
      state_q <= nxt;
      if (state_q == ST_DEC && !is_mem) begin
        halted_q <= 1'b1;
        abend_q  <= !is_stop;
      end
      if (state_q == ST_CHK && ov) begin
        halted_q <= 1'b1;
        abend_q  <= 1'b1;
      end
    end
  end

  assign halted = halted_q;
  assign abend  = abend_q;

  assert_single_write_R5: assert property (@(posedge clk) disable iff (rst)
    ctl.we |=> !ctl.we);
  assert_ovf_halts_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CHK && ov) |=> (halted_q && abend_q));
  assert_abend_halted_R8: assert property (@(posedge clk) disable iff (rst)
    abend_q |-> halted_q);
  assert_halt_hold_R9: assert property (@(posedge clk) disable iff (rst)
    halted_q |=> (halted_q && $stable(abend_q)));

endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
  import acc_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int OP_W   = 8,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic                     clk,
  input  logic                     rst,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic                     mem_we,
  output logic [OP_W+ADDR_W-1:0]   mem_wdata,
  input  logic [OP_W+ADDR_W-1:0]   mem_rdata,
  output logic                     halted,
  output logic                     abend,
  output logic                     ovf
);

  seq_ctl_t        ctl;
  logic [OP_W-1:0] ir_op;

  acc_seq_ctrl #(.OP_W(OP_W)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .ir_op  (ir_op),
    .ov     (ovf),
    .ctl    (ctl),
    .halted (halted),
    .abend  (abend)
  );

  acc_seq_datapath #(.ADDR_W(ADDR_W), .OP_W(OP_W), .RESET_PC(RESET_PC)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .ir_op     (ir_op),
    .ov        (ovf)
  );

  assign mem_we = ctl.we;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!halted && !abend && !ovf && !mem_we));
  assert_no_write_halted_R9: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_we);

endmodule

// File: tb/acc_cpu_seq_tb.sv
module acc_cpu_seq_tb;
  localparam int CLK_NS = 10;
  localparam logic [7:0] START = 8'h23;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  mem_addr;
  logic        mem_we;
  logic [15:0] mem_wdata, mem_rdata;
  logic        halted, abend, ovf;

  always #(CLK_NS/2) clk = ~clk;

  acc_cpu_seq #(.ADDR_W(8), .OP_W(8), .RESET_PC(START)) u_dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .halted(halted), .abend(abend), .ovf(ovf)
  );

  // bench memory, synchronous read, with a loader port
  logic [15:0] ram [0:255];
  logic        ld_en = 1'b0;
  logic [7:0]  ld_a = '0;
  logic [15:0] ld_d = '0;
  always @(posedge clk) begin
    if (ld_en) ram[ld_a] <= ld_d;
    else if (mem_we) ram[mem_addr] <= mem_wdata;
    mem_rdata <= ram[mem_addr];
  end

  typedef struct {
    bit h, ab, ov, we;
    bit [7:0] wa;
    bit [15:0] wd;
  } exp_t;

  exp_t q[$];
  bit [15:0] img [256];
  bit mh, mab, mov;
  int total = 0, bad = 0;

  task automatic push_n(int n);
    repeat (n) begin
      exp_t e;
      e.h = mh; e.ab = mab; e.ov = mov; e.we = 1'b0; e.wa = '0; e.wd = '0;
      q.push_back(e);
    end
  endtask

  task automatic push_wr(bit [7:0] a, bit [15:0] d);
    exp_t e;
    e.h = mh; e.ab = mab; e.ov = mov; e.we = 1'b1; e.wa = a; e.wd = d;
    q.push_back(e);
  endtask

  // instruction-level model expanded into expected per-cycle outputs
  task automatic build_model();
    bit [15:0] m [256];
    bit [7:0]  pc, op, ad;
    bit [15:0] acc, w, s;
    int guard;
    for (int i = 0; i < 256; i++) m[i] = img[i];
    pc = START; acc = '0; mh = 0; mab = 0; mov = 0; guard = 0;
    q.delete();
    while (!mh && guard < 200) begin
      w = m[pc]; op = w[15:8]; ad = w[7:0];
      push_n(5);                       // R2 fetch, offsets 0..4
      pc = pc + 8'd1;
      case (op)
        8'h01: begin push_n(4); acc = m[ad]; push_n(1); end          // R3
        8'h02: begin                                                  // R4
          push_n(4);
          s = acc + m[ad];
          if (acc[15] == m[ad][15] && s[15] != acc[15]) mov = 1;
          acc = s;
          push_n(1);                   // check cycle sees new flag
          if (mov) begin mh = 1; mab = 1; end                         // R6
        end
        8'h03: begin push_n(2); push_wr(ad, acc); m[ad] = acc; push_n(1); end // R5
        8'h04: mh = 1;                                                // R7
        default: begin mh = 1; mab = 1; end                           // R8
      endcase
      guard++;
    end
    push_n(8);                         // R9 halted tail
  endtask

  task automatic check(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic run(string tag);
    rst = 1'b1;
    ld_en = 1'b1;
    for (int a = 0; a < 256; a++) begin
      ld_a = 8'(a); ld_d = img[a];
      @(negedge clk);
    end
    ld_en = 1'b0;
    @(negedge clk);
    // R1 reset state
    check({tag, " R1 reset halted"}, int'(halted), 0);
    check({tag, " R1 reset abend"}, int'(abend), 0);
    check({tag, " R1 reset ovf/we"}, int'({ovf, mem_we}), 0);
    build_model();
    rst = 1'b0;
    for (int c = 0; c < q.size(); c++) begin
      exp_t e = q[c];
      total++;
      if (halted !== e.h || abend !== e.ab || ovf !== e.ov || mem_we !== e.we ||
          (e.we && (mem_addr !== e.wa || mem_wdata !== e.wd))) begin
        bad++;
        $display("FAIL %s cycle %0d: got h=%b ab=%b ov=%b we=%b a=%h d=%h expected h=%b ab=%b ov=%b we=%b a=%h d=%h",
                 tag, c, halted, abend, ovf, mem_we, mem_addr, mem_wdata,
                 e.h, e.ab, e.ov, e.we, e.wa, e.wd);
      end
      @(negedge clk);
    end
  endtask

  task automatic clear_img();
    for (int i = 0; i < 256; i++) img[i] = '0;
  endtask

  initial begin
    #(CLK_NS * 200000);
    bad++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R10 sample program
    clear_img();
    img[8'h20] = 16'd450; img[8'h21] = 16'd300;
    img[8'h23] = 16'h0120; img[8'h24] = 16'h0221;
    img[8'h25] = 16'h0322; img[8'h26] = 16'h0400;
    run("R3 R5 R7 R10 sample");
    check("R10 result at x22", int'(ram[8'h22]), 750);
    check("R7 normal end", int'({halted, abend}), 2);

    // R4 R6 positive overflow, following store must not happen
    clear_img();
    img[8'h20] = 16'h7000; img[8'h21] = 16'h2000;
    img[8'h23] = 16'h0120; img[8'h24] = 16'h0221;
    img[8'h25] = 16'h0322; img[8'h26] = 16'h0400;
    run("R4 R6 R9 pos overflow");
    check("R9 no store after abend", int'(ram[8'h22]), 0);
    check("R6 abend after overflow", int'({halted, abend, ovf}), 7);

    // R4 negative overflow
    clear_img();
    img[8'h20] = 16'h8000; img[8'h21] = 16'h8000;
    img[8'h23] = 16'h0120; img[8'h24] = 16'h0221;
    img[8'h25] = 16'h0322; img[8'h26] = 16'h0400;
    run("R4 R6 neg overflow");
    check("R4 neg overflow store blocked", int'(ram[8'h22]), 0);

    // R4 R5 wrap to zero without overflow, then a second add
    clear_img();
    img[8'h20] = 16'hFFFF; img[8'h21] = 16'h0001;
    img[8'h23] = 16'h0120; img[8'h24] = 16'h0221; img[8'h25] = 16'h0330;
    img[8'h26] = 16'h0221; img[8'h27] = 16'h0331; img[8'h28] = 16'h0400;
    ram[8'h30] = 16'hAAAA;
    run("R4 R5 wrap");
    check("R4 wrap sum at x30", int'(ram[8'h30]), 0);
    check("R5 second store at x31", int'(ram[8'h31]), 1);
    check("R4 no overflow on wrap", int'(ovf), 0);

    // R8 undefined code after a store
    clear_img();
    img[8'h20] = 16'd450;
    img[8'h23] = 16'h0120; img[8'h24] = 16'h0330; img[8'h25] = 16'h0921;
    img[8'h26] = 16'h0331;
    run("R8 undefined 0x09");
    check("R8 store before undefined", int'(ram[8'h30]), 450);
    check("R8 nothing after undefined", int'(ram[8'h31]), 0);

    // R8 operation code zero
    clear_img();
    img[8'h23] = 16'h0020;
    run("R8 code zero");
    check("R8 code zero abend", int'({halted, abend}), 3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule